// File: doc/BRIEF.md
# Compressed Extension Instruction Expander

This block turns a 16-bit compressed instruction from the extra-compact byte, halfword and bit-manipulation subset into the equivalent 32-bit base-ISA instruction. It sits between the fetch alignment logic and the main decoder. The main decoder then sees only full-width instructions and needs no knowledge of the compressed forms.

The block is purely combinational. A mode input selects 32-bit or 64-bit operation. The outputs are the expanded word, a valid flag and an illegal flag. The subset covered is:

- unsigned byte load, signed and unsigned halfword loads;
- byte and halfword stores;
- the six unary operations: zero-extend byte, halfword and word, sign-extend byte and halfword, and bitwise invert;
- the two-operand multiply.

Any other 16-bit pattern is reported illegal. So is zero-extend word decoded in 32-bit mode.

Top module: `zcbx_expander`

## Requirements
- R1: `x_valid` is always the inverse of `x_illegal`. Whenever `x_illegal` is 1, `x_inst` is all zeros. Every valid expansion ends in bits [1:0] = 11.
- R2: Bits [1:0] = 00 with bits [15:10] = 100000 expands to `lbu`. The offset is {bit 5, bit 6}: bit 6 is offset bit 0 and bit 5 is offset bit 1. The opcode is 0000011 and funct3 is 100.
- R3: Bits [1:0] = 00 with bits [15:10] = 100001 expands to a halfword load. Bit 6 = 1 gives `lh` (funct3 001) and bit 6 = 0 gives `lhu` (funct3 101). The offset is bit 5 times 2.
- R4: Bits [1:0] = 00 with bits [15:10] = 100010 expands to `sb` (opcode 0100011, funct3 000). It uses the same byte offset as R2.
- R5: Bits [1:0] = 00 with bits [15:10] = 100011 and bit 6 = 0 expands to `sh` (funct3 001) with offset bit 5 times 2. With bit 6 = 1 the word is illegal.
- R6: Each 3-bit register field n maps to register x(8+n). The base register, or the destination that is also first source, comes from bits [9:7]. The load destination or store data register comes from bits [4:2].
- R7: The unary group is bits [15:10] = 100111, bits [1:0] = 01 and bits [6:5] = 11, with the sub-code in bits [4:2]. Sub-code 000 (zero-extend byte) expands to `andi rd,rd,255`. Sub-code 101 (invert) expands to `xori rd,rd,-1`.
- R8: Sub-code 001 expands to sign-extend byte and sub-code 011 to sign-extend halfword. These are the standard bit-manipulation I-type forms: immediate 0x604 or 0x605, funct3 001, opcode 0010011.
- R9: Sub-code 010 (zero-extend halfword) expands to funct7 0000100, rs2 x0, funct3 100. The opcode is 0110011 when `rv64_en` = 0 and 0111011 when `rv64_en` = 1.
- R10: Sub-code 100 (zero-extend word) expands to `add.uw rd,rd,x0` (funct7 0000100, funct3 000, opcode 0111011) when `rv64_en` = 1. It is illegal when `rv64_en` = 0.
- R11: Bits [15:10] = 100111, bits [6:5] = 10 and bits [1:0] = 01 expand to `mul rd,rd,rs2` (funct7 0000001, opcode 0110011).
- R12: The all-zero word is illegal. Unary sub-codes 110 and 111 are illegal. Every pattern not named in R2 to R11 is illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| c_inst | input | 16 | Compressed instruction word |
| rv64_en | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| x_inst | output | 32 | Expanded 32-bit instruction, zero when illegal |
| x_valid | output | 1 | Input matched a supported form |
| x_illegal | output | 1 | Input is unsupported or not legal in this mode |

## Verification
The bench drives every 16-bit pattern in both modes, so the corner cases listed here are all reached.

- **Byte offset bit order.** A design that swaps bits 5 and 6 in the byte offset produces offsets 1 and 2 exchanged.
- **Halfword bit 6.** A design that ignores bit 6 on halfword stores accepts a reserved pattern as `sh`. One that reverses the signed/unsigned selection loads halfwords with the wrong extension.
- **Zero-extend word in 32-bit mode.** A design that forgets the mode check emits `add.uw` on a 32-bit machine.
- **Zero-extend halfword opcode.** A design that forgets the mode switch for zero-extend halfword emits the wrong opcode in one of the two modes.
- **Reserved sub-codes and the zero word.** Sub-codes 110 and 111, and the all-zero word, must come back illegal with a zero output. They must not alias onto a neighbouring operation.

// File: rtl/zcbx_pkg.sv
`timescale 1ns/1ps
package zcbx_pkg;

    localparam int XR_W = 5;

    typedef enum logic [3:0] {
        ZOP_NONE, ZOP_LBU, ZOP_LHU, ZOP_LH, ZOP_SB, ZOP_SH,
        ZOP_ZEXTB, ZOP_SEXTB, ZOP_ZEXTH, ZOP_SEXTH, ZOP_ZEXTW,
        ZOP_NOT, ZOP_MUL
    } zop_e;

    typedef struct packed {
        logic [XR_W-1:0] reg_hi;   // from bits [9:7]
        logic [XR_W-1:0] reg_lo;   // from bits [4:2]
        logic [11:0]     off_b;    // byte offset
        logic [11:0]     off_h;    // halfword offset
    } zfields_t;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_REG   = 7'b0110011;
    localparam logic [6:0] OPC_REG32 = 7'b0111011;

    function automatic logic [31:0] enc_i(logic [11:0] imm, logic [XR_W-1:0] rs1,
                                          logic [2:0] f3, logic [XR_W-1:0] rd,
                                          logic [6:0] opc);
        return {imm, rs1, f3, rd, opc};
    endfunction

    function automatic logic [31:0] enc_r(logic [6:0] f7, logic [XR_W-1:0] rs2,
                                          logic [XR_W-1:0] rs1, logic [2:0] f3,
                                          logic [XR_W-1:0] rd, logic [6:0] opc);
        return {f7, rs2, rs1, f3, rd, opc};
    endfunction

    function automatic logic [31:0] enc_s(logic [11:0] imm, logic [XR_W-1:0] rs2,
                                          logic [XR_W-1:0] rs1, logic [2:0] f3,
                                          logic [6:0] opc);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
    endfunction

endpackage

// File: rtl/zcbx_classify.sv
`timescale 1ns/1ps
module zcbx_classify
    import zcbx_pkg::*;
(
    input  logic [15:0] c_inst,
    input  logic        rv64_en,
    output zop_e        op
);
    logic [1:0] quad;
    logic [5:0] f6;

    assign quad = c_inst[1:0];
    assign f6   = c_inst[15:10];

    always_comb begin
        op = ZOP_NONE;
        if (quad == 2'b00) begin
            unique case (f6)
                6'b100000: op = ZOP_LBU;
                6'b100001: op = c_inst[6] ? ZOP_LH : ZOP_LHU;
                6'b100010: op = ZOP_SB;
                6'b100011: op = c_inst[6] ? ZOP_NONE : ZOP_SH;
                default:   op = ZOP_NONE;
            endcase
        end else if (quad == 2'b01 && f6 == 6'b100111) begin
            if (c_inst[6:5] == 2'b10) begin
                op = ZOP_MUL;
            end else if (c_inst[6:5] == 2'b11) begin
                unique case (c_inst[4:2])
                    3'b000:  op = ZOP_ZEXTB;
                    3'b001:  op = ZOP_SEXTB;
                    3'b010:  op = ZOP_ZEXTH;
                    3'b011:  op = ZOP_SEXTH;
                    3'b100:  op = rv64_en ? ZOP_ZEXTW : ZOP_NONE;
                    3'b101:  op = ZOP_NOT;
                    default: op = ZOP_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/zcbx_fields.sv
`timescale 1ns/1ps
module zcbx_fields
    import zcbx_pkg::*;
#(
    parameter int CREG_W    = 3,
    parameter int XREG_BASE = 8
) (
    input  logic [15:0] c_inst,
    output zfields_t    flds
);
    localparam int PAD_W = XR_W - CREG_W;
    localparam logic [XR_W-1:0] BASE = XREG_BASE[XR_W-1:0];

    logic [CREG_W-1:0] c_hi;
    logic [CREG_W-1:0] c_lo;

    assign c_hi = c_inst[7 +: CREG_W];
    assign c_lo = c_inst[2 +: CREG_W];

    always_comb begin
        flds.reg_hi = BASE + {{PAD_W{1'b0}}, c_hi};
        flds.reg_lo = BASE + {{PAD_W{1'b0}}, c_lo};
        flds.off_b  = {10'd0, c_inst[5], c_inst[6]};
        flds.off_h  = {10'd0, c_inst[5], 1'b0};
    end
endmodule

// File: rtl/zcbx_assemble.sv
`timescale 1ns/1ps
module zcbx_assemble
    import zcbx_pkg::*;
(
    input  zop_e        op,
    input  zfields_t    flds,
    input  logic        rv64_en,
    output logic [31:0] word
);
    localparam logic [XR_W-1:0] X0 = '0;

    logic [XR_W-1:0] ra;
    logic [XR_W-1:0] rb;
    logic [6:0]      zexth_opc;

    assign ra        = flds.reg_hi;
    assign rb        = flds.reg_lo;
    assign zexth_opc = rv64_en ? OPC_REG32 : OPC_REG;

    always_comb begin
        unique case (op)
            ZOP_LBU:   word = enc_i(flds.off_b, ra, 3'b100, rb, OPC_LOAD);
            ZOP_LHU:   word = enc_i(flds.off_h, ra, 3'b101, rb, OPC_LOAD);
            ZOP_LH:    word = enc_i(flds.off_h, ra, 3'b001, rb, OPC_LOAD);
            ZOP_SB:    word = enc_s(flds.off_b, rb, ra, 3'b000, OPC_STORE);
            ZOP_SH:    word = enc_s(flds.off_h, rb, ra, 3'b001, OPC_STORE);
            ZOP_ZEXTB: word = enc_i(12'h0FF, ra, 3'b111, ra, OPC_IMM);
            ZOP_NOT:   word = enc_i(12'hFFF, ra, 3'b100, ra, OPC_IMM);
            ZOP_SEXTB: word = enc_i(12'h604, ra, 3'b001, ra, OPC_IMM);
            ZOP_SEXTH: word = enc_i(12'h605, ra, 3'b001, ra, OPC_IMM);
            ZOP_ZEXTH: word = enc_r(7'b0000100, X0, ra, 3'b100, ra, zexth_opc);
            ZOP_ZEXTW: word = enc_r(7'b0000100, X0, ra, 3'b000, ra, OPC_REG32);
            ZOP_MUL:   word = enc_r(7'b0000001, rb, ra, 3'b000, ra, OPC_REG);
            ZOP_NONE:  word = '0;
            default:   word = '0;
        endcase
    end
endmodule

// File: rtl/zcbx_expander.sv
`timescale 1ns/1ps
module zcbx_expander
    import zcbx_pkg::*;
#(
    parameter int CREG_W    = 3,
    parameter int XREG_BASE = 8
) (
    input  logic [15:0] c_inst,
    input  logic        rv64_en,
    output logic [31:0] x_inst,
    output logic        x_valid,
    output logic        x_illegal
);
    zop_e     op;
    zfields_t flds;

    zcbx_classify u_cls (
        .c_inst  (c_inst),
        .rv64_en (rv64_en),
        .op      (op)
    );

    zcbx_fields #(
        .CREG_W    (CREG_W),
        .XREG_BASE (XREG_BASE)
    ) u_fld (
        .c_inst (c_inst),
        .flds   (flds)
    );

    zcbx_assemble u_asm (
        .op      (op),
        .flds    (flds),
        .rv64_en (rv64_en),
        .word    (x_inst)
    );

    assign x_illegal = (op == ZOP_NONE);
    assign x_valid   = ~x_illegal;
endmodule

// File: rtl/zcbx_expander_chk.sv
`timescale 1ns/1ps
module zcbx_expander_chk (
    input logic [15:0] c_inst,
    input logic        rv64_en,
    input logic [31:0] x_inst,
    input logic        x_valid,
    input logic        x_illegal
);
    logic is_unary;
    assign is_unary = (c_inst[15:10] == 6'b100111) && (c_inst[1:0] == 2'b01)
                      && (c_inst[6:5] == 2'b11);

    always_comb begin
        // R1
        flag_pair_chk: assert (x_valid != x_illegal);
        // R1
        zero_on_illegal_chk: assert (!x_illegal || x_inst == 32'd0);
        // R1
        full_width_chk: assert (!x_valid || x_inst[1:0] == 2'b11);
        // R10
        zextw_rv32_chk: assert (!(is_unary && c_inst[4:2] == 3'b100 && !rv64_en) || x_illegal);
        // R12
        zero_word_chk: assert (c_inst != 16'd0 || x_illegal);
        // R12
        reserved_sub_chk: assert (!(is_unary && c_inst[4:3] == 2'b11) || x_illegal);
        // R6
        load_base_chk: assert (!(x_valid && x_inst[6:0] == 7'b0000011)
                               || x_inst[19:18] == 2'b01);
    end
endmodule

bind zcbx_expander zcbx_expander_chk u_chk (
    .c_inst    (c_inst),
    .rv64_en   (rv64_en),
    .x_inst    (x_inst),
    .x_valid   (x_valid),
    .x_illegal (x_illegal)
);

// File: tb/zcbx_expander_test.sv
`timescale 1ns/1ps
module zcbx_expander_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] c_inst = 16'd0;
    logic        rv64_en = 1'b0;
    logic [31:0] x_inst;
    logic        x_valid;
    logic        x_illegal;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    zcbx_expander uut (
        .c_inst    (c_inst),
        .rv64_en   (rv64_en),
        .x_inst    (x_inst),
        .x_valid   (x_valid),
        .x_illegal (x_illegal)
    );

    function automatic int unsigned itype(int unsigned imm, int unsigned rs1,
                                          int unsigned f3, int unsigned rd, int unsigned op);
        return (imm << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op;
    endfunction

    function automatic int unsigned stype(int unsigned imm, int unsigned rs2,
                                          int unsigned rs1, int unsigned f3);
        return ((imm >> 5) << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12)
               | ((imm & 31) << 7) | 32'h23;
    endfunction

    // Behavioural model written from the requirements.
    task automatic ref_model(input int unsigned c, input bit r64,
                             output int unsigned w, output bit ill, output string tag);
        int unsigned q  = c & 3;
        int unsigned f6 = (c >> 10) & 63;
        int unsigned a  = ((c >> 7) & 7) + 8;
        int unsigned b  = ((c >> 2) & 7) + 8;
        int unsigned b6 = (c >> 6) & 1;
        int unsigned b5 = (c >> 5) & 1;
        int unsigned sub = (c >> 2) & 7;
        w = 0; ill = 1'b1; tag = "R12";
        if (q == 0 && f6 == 32) begin
            w = itype(b6 + 2*b5, a, 4, b, 3); ill = 0; tag = "R2";
        end else if (q == 0 && f6 == 33) begin
            w = itype(2*b5, a, b6 ? 1 : 5, b, 3); ill = 0; tag = "R3";
        end else if (q == 0 && f6 == 34) begin
            w = stype(b6 + 2*b5, b, a, 0); ill = 0; tag = "R4";
        end else if (q == 0 && f6 == 35) begin
            tag = "R5";
            if (b6 == 0) begin w = stype(2*b5, b, a, 1); ill = 0; end
        end else if (q == 1 && f6 == 39 && b6 == 1 && b5 == 0) begin
            w = (1 << 25) | (b << 20) | (a << 15) | (a << 7) | 32'h33; ill = 0; tag = "R11";
        end else if (q == 1 && f6 == 39 && b6 == 1 && b5 == 1) begin
            case (sub)
                0: begin w = itype(255, a, 7, a, 32'h13); ill = 0; tag = "R7"; end
                5: begin w = itype(4095, a, 4, a, 32'h13); ill = 0; tag = "R7"; end
                1: begin w = itype(32'h604, a, 1, a, 32'h13); ill = 0; tag = "R8"; end
                3: begin w = itype(32'h605, a, 1, a, 32'h13); ill = 0; tag = "R8"; end
                2: begin
                    w = (4 << 25) | (a << 15) | (4 << 12) | (a << 7) | (r64 ? 32'h3B : 32'h33);
                    ill = 0; tag = "R9";
                end
                4: begin
                    tag = "R10";
                    if (r64) begin w = (4 << 25) | (a << 15) | (a << 7) | 32'h3B; ill = 0; end
                end
                default: tag = "R12";
            endcase
        end
    endtask

    task automatic check(input string tag, input int unsigned ew, input bit eill);
        n_vec++;
        if (x_inst !== ew || x_illegal !== eill || x_valid !== !eill) begin
            n_fail++;
            $display("FAIL %s R1: in=%h rv64=%0d got word=%h ill=%0b val=%0b exp word=%h ill=%0b val=%0b",
                     tag, c_inst, rv64_en, x_inst, x_illegal, x_valid, ew, eill, !eill);
        end
    endtask

    task automatic apply(input logic [15:0] c, input bit r64);
        @(posedge clk);
        #1;
        c_inst  = c;
        rv64_en = r64;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : main
        int unsigned ew;
        bit          eill;
        string       tag;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R12: state after reset with the all-zero word is illegal
        @(negedge clk);
        check("R12", 32'd0, 1'b1);

        // R2 R6: lbu x9,3(x8)
        apply(16'h8064, 1'b0);
        check("R2", 32'h00344483, 1'b0);
        // R7: invert x10 -> xori x10,x10,-1
        apply(16'h9D75, 1'b1);
        check("R7", 32'hFFF54513, 1'b0);
        // R10: zero-extend word x8 in 32-bit mode is illegal
        apply(16'h9C71, 1'b0);
        check("R10", 32'd0, 1'b1);
        // R10: same word in 64-bit mode -> add.uw x8,x8,x0
        apply(16'h9C71, 1'b1);
        check("R10", 32'h0804043B, 1'b0);
        // R5: halfword store with bit 6 set is illegal
        apply(16'h8C40, 1'b1);
        check("R5", 32'd0, 1'b1);

        // Exhaustive sweep, both modes, R1 through R12
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 65536; v++) begin
                apply(v[15:0], m[0]);
                ref_model(v, m[0], ew, eill, tag);
                check(tag, ew, eill);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule